// File: doc/BRIEF.md
# IPv4 Forwarding Header Processor

This block is one streaming stage of a packet datapath, placed between an input arbiter and a set of per-port output queues. Packets arrive as 64-bit data words. Each word carries an 8-bit control tag. The first word of a packet is a module header, which holds the packet's byte length and its ingress port. Output ports interleave MAC interfaces and CPU queues: MAC interface i is port 2i, and its CPU companion queue is port 2i+1.

The stage buffers a whole packet before it decides anything. It then classifies the packet and takes one of four actions:
- **Drop** the packet.
- **Divert** it, unmodified, to the CPU queue paired with its ingress MAC port.
- **Bypass** a packet that came from a CPU queue straight to the paired MAC port.
- **Forward** it. The stage requests a next-hop result on a small lookup interface. It then decrements the TTL and patches the IP header checksum incrementally. It rewrites both Ethernet addresses.

In every case that is not a drop, the chosen port is written into the module header as a one-hot map.

Top module: `ipfwd_hdr_proc`

## Requirements
- R1: `in_rdy` is high only while a packet is being received. A word is taken in a cycle where `in_wr` and `in_rdy` are both high. `out_wr` is never high while `in_rdy` is high, so a packet is fully buffered before any word leaves.
- R2: Word 0 of a packet is its module header, with a non-zero control tag other than 0x10. Bits [15:0] of that word hold the ingress port number and bits [31:16] hold the output-port one-hot map. Data words carry tag 0x00, except the final word, which carries 0x10. On output, the stage changes only bits [31:16] of word 0, setting them to the one-hot code of the chosen port.
- R3: On a forwarded packet, the TTL (data word 2, bits [15:8]) drops by one. The header checksum (data word 3, bits [63:48]) becomes the old value plus 0x0100 in one's-complement arithmetic, with the carry out of bit 15 added back in (end-around carry), including when the addition wraps.
- R4: On a forwarded packet, the destination MAC (data word 0, bits [63:16]) becomes `lu_next_mac`. The source MAC (data word 0 bits [15:0] followed by data word 1 bits [63:32]) becomes the egress port's MAC. Port p has the MAC `MAC_BASE[47:8]` followed by the 8-bit value p. The egress port is 2×`lu_mac_idx`.
- R5: A packet from a MAC port whose TTL is 0 or 1 leaves on the ingress port plus one. All its data words are unchanged.
- R6: A packet from a MAC port goes to the ingress port plus one, unchanged, if any of these holds:
  - its ethertype (data word 1, bits [31:16]) is not 0x0800;
  - its IP version (data word 1, bits [15:12]) is not 4;
  - its header length (data word 1, bits [11:8]) is not 5;
  - its total length (data word 2, bits [63:48]) lies outside 64..1500.
- R7: A packet from a MAC port whose header checksum is wrong is dropped and produces no output word. The check is the one's-complement sum of the ten 16-bit IP header fields, which must equal 0xFFFF.
- R8: A packet from a MAC port whose destination MAC differs from the ingress port's MAC is dropped.
- R9: A packet from an odd (CPU) port leaves unchanged on the port one below it and raises no lookup request.
- R10: `lu_req` is raised only for a packet that will be forwarded. It stays high, with `lu_dst_ip` stable, until `lu_ack`. `lu_dst_ip` is data word 3 bits [15:0] followed by data word 4 bits [63:48]. The result is taken in the cycle of `lu_ack`.
- R11: When several conditions hold at once, the first one in this list decides the action:
  1. CPU ingress
  2. destination MAC mismatch
  3. not IPv4
  4. header options
  5. bad checksum
  6. length out of range
  7. TTL expiry
- R12: Output words leave only in cycles where `out_rdy` is high, in their original order. Under any pattern of stalls, none is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | Incoming packet word |
| in_ctrl | input | 8 | Control tag of incoming word |
| in_wr | input | 1 | Upstream offers a word |
| in_rdy | output | 1 | Stage accepts a word |
| out_data | output | 64 | Outgoing packet word |
| out_ctrl | output | 8 | Control tag of outgoing word |
| out_wr | output | 1 | Outgoing word transferred this cycle |
| out_rdy | input | 1 | Downstream can take a word |
| lu_req | output | 1 | Next-hop lookup request |
| lu_dst_ip | output | 32 | Destination IP for the lookup |
| lu_ack | input | 1 | Lookup result valid |
| lu_mac_idx | input | $clog2(NUM_MACS) | Egress MAC interface index |
| lu_next_mac | input | 48 | Next-hop MAC address |

## Verification
The decision step can meet several classification conditions in the same cycle. The cases of interest are:
- a bad checksum together with an expired TTL;
- a destination MAC mismatch together with a bad checksum;
- a CPU ingress together with a foreign destination MAC and TTL 0.

The bench builds such packets on purpose. It judges the outcome from the priority order, either no output words or the exact port and payload. The checksum rewrite can also fall in a cycle where downstream stalls. Forwarded packets are therefore sent while `out_rdy` drops every third cycle. The rewritten words are compared at the port against the bench's own one's-complement sum.

// File: rtl/ipfwd_pkg.sv
package ipfwd_pkg;
  localparam logic [7:0]  CTRL_LAST  = 8'h10;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam int          HDR_WORDS  = 5;

  typedef enum logic [1:0] {
    ACT_DROP   = 2'd0,
    ACT_CPU    = 2'd1,
    ACT_BYPASS = 2'd2,
    ACT_FWD    = 2'd3
  } act_t;

  typedef struct packed {
    logic [63:0] w4;
    logic [63:0] w3;
    logic [63:0] w2;
    logic [63:0] w1;
    logic [63:0] w0;
  } l2l3_hdr_t;

  function automatic logic [15:0] ones_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] ip_hdr_sum(input l2l3_hdr_t h);
    logic [15:0] acc;
    acc = h.w1[15:0];
    acc = ones_add(acc, h.w2[63:48]);
    acc = ones_add(acc, h.w2[47:32]);
    acc = ones_add(acc, h.w2[31:16]);
    acc = ones_add(acc, h.w2[15:0]);
    acc = ones_add(acc, h.w3[63:48]);
    acc = ones_add(acc, h.w3[47:32]);
    acc = ones_add(acc, h.w3[31:16]);
    acc = ones_add(acc, h.w3[15:0]);
    acc = ones_add(acc, h.w4[63:48]);
    return acc;
  endfunction

  function automatic logic [47:0] port_mac(input logic [47:0] base, input logic [7:0] p);
    return {base[47:8], p};
  endfunction

  function automatic act_t pick_action(input logic from_cpu, input logic dmac_hit,
                                       input logic is_ipv4, input logic has_opts,
                                       input logic csum_good, input logic len_ok,
                                       input logic ttl_expired);
    if (from_cpu)          return ACT_BYPASS;
    else if (!dmac_hit)    return ACT_DROP;
    else if (!is_ipv4)     return ACT_CPU;
    else if (has_opts)     return ACT_CPU;
    else if (!csum_good)   return ACT_DROP;
    else if (!len_ok)      return ACT_CPU;
    else if (ttl_expired)  return ACT_CPU;
    else                   return ACT_FWD;
  endfunction
endpackage

// File: rtl/ipfwd_pkt_buf.sv
module ipfwd_pkt_buf #(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_en,
  input  logic [71:0] wdata,
  input  logic        rd_adv,
  output logic [71:0] rdata,
  output logic        rd_first,
  output logic        rd_last
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [71:0]     mem [DEPTH];
  logic [ADDR_W:0] wr_cnt;
  logic [ADDR_W-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_cnt <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en && wr_cnt < (ADDR_W+1)'(DEPTH)) wr_cnt <= wr_cnt + 1'b1;
      if (rd_adv) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_cnt < (ADDR_W+1)'(DEPTH)) mem[wr_cnt[ADDR_W-1:0]] <= wdata;
  end

  assign rdata    = mem[rd_ptr];
  assign rd_first = (rd_ptr == '0);
  assign rd_last  = (({1'b0, rd_ptr} + 1'b1) == wr_cnt);
endmodule

// File: rtl/ipfwd_hdr_parse.sv
module ipfwd_hdr_parse
  import ipfwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        take,
  input  logic [63:0] in_data,
  input  logic [7:0]  in_ctrl,
  output l2l3_hdr_t   hdr,
  output logic [15:0] src_port
);
  logic        first_q;
  logic [2:0]  dcnt_q;
  logic [63:0] hw_q [HDR_WORDS];
  logic        is_data;

  assign is_data = (in_ctrl == 8'h00) || (in_ctrl == CTRL_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      first_q  <= 1'b1;
      dcnt_q   <= '0;
      src_port <= '0;
    end else if (take) begin
      first_q <= 1'b0;
      if (first_q) src_port <= in_data[15:0];
      if (is_data && dcnt_q != 3'd7) dcnt_q <= dcnt_q + 3'd1;
    end
  end

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_hw
    always_ff @(posedge clk) begin
      if (!rst_n) hw_q[g] <= '0;
      else if (take && is_data && dcnt_q == 3'(g)) hw_q[g] <= in_data;
    end
  end

  assign hdr = '{w4: hw_q[4], w3: hw_q[3], w2: hw_q[2], w1: hw_q[1], w0: hw_q[0]};
endmodule

// File: rtl/ipfwd_rewrite.sv
module ipfwd_rewrite
  import ipfwd_pkg::*;
#(
  parameter int PORT_W = 3
) (
  input  logic [63:0]       in_word,
  input  logic              is_first,
  input  logic              is_data,
  input  logic [2:0]        didx,
  input  act_t              act,
  input  logic [PORT_W-1:0] oport,
  input  logic [47:0]       next_mac,
  input  logic [47:0]       egress_mac,
  output logic [63:0]       out_word
);
  always_comb begin
    out_word = in_word;
    if (is_first) out_word[31:16] = 16'd1 << oport;
    if (act == ACT_FWD && is_data) begin
      case (didx)
        3'd0: out_word = {next_mac, egress_mac[47:32]};
        3'd1: out_word[63:32] = egress_mac[31:0];
        3'd2: out_word[15:8]  = in_word[15:8] - 8'd1;
        3'd3: out_word[63:48] = ones_add(in_word[63:48], 16'h0100);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipfwd_hdr_proc.sv
module ipfwd_hdr_proc
  import ipfwd_pkg::*;
#(
  parameter int          NUM_MACS  = 4,
  parameter int          BUF_DEPTH = 256,
  parameter logic [47:0] MAC_BASE  = 48'h02_00_00_00_00_00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [63:0]                 in_data,
  input  logic [7:0]                  in_ctrl,
  input  logic                        in_wr,
  output logic                        in_rdy,
  output logic [63:0]                 out_data,
  output logic [7:0]                  out_ctrl,
  output logic                        out_wr,
  input  logic                        out_rdy,
  output logic                        lu_req,
  output logic [31:0]                 lu_dst_ip,
  input  logic                        lu_ack,
  input  logic [$clog2(NUM_MACS)-1:0] lu_mac_idx,
  input  logic [47:0]                 lu_next_mac
);
  localparam int IDX_W  = $clog2(NUM_MACS);
  localparam int PORT_W = IDX_W + 1;

  typedef enum logic [1:0] {S_RECV, S_DECIDE, S_LOOK, S_SEND} st_t;

  st_t               state;
  act_t              act_q;
  logic [PORT_W-1:0] oport_q;
  logic [47:0]       nmac_q;
  logic [2:0]        didx_q;

  logic        take, in_last, pkt_done, dec_valid;
  l2l3_hdr_t   hdr;
  logic [15:0] src_port;
  logic [PORT_W-1:0] src_p;
  logic [71:0] rd_word;
  logic        rd_first, rd_last, rd_is_data;

  // named classification events
  logic src_odd, dmac_hit, is_ipv4, has_opts, csum_good, len_ok, ttl_expired;
  act_t dec_act;

  assign in_rdy    = (state == S_RECV);
  assign take      = in_wr && in_rdy;
  assign in_last   = take && (in_ctrl == CTRL_LAST);
  assign dec_valid = (state == S_DECIDE);
  assign src_p     = src_port[PORT_W-1:0];

  ipfwd_hdr_parse u_parse (
    .clk(clk), .rst_n(rst_n), .clr(pkt_done), .take(take),
    .in_data(in_data), .in_ctrl(in_ctrl), .hdr(hdr), .src_port(src_port)
  );

  ipfwd_pkt_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(pkt_done), .wr_en(take),
    .wdata({in_ctrl, in_data}), .rd_adv(out_wr),
    .rdata(rd_word), .rd_first(rd_first), .rd_last(rd_last)
  );

  assign src_odd     = src_p[0];
  assign dmac_hit    = (hdr.w0[63:16] == port_mac(MAC_BASE, 8'(src_p)));
  assign is_ipv4     = (hdr.w1[31:16] == ETYPE_IPV4) && (hdr.w1[15:12] == 4'd4);
  assign has_opts    = (hdr.w1[11:8] != 4'd5);
  assign csum_good   = (ip_hdr_sum(hdr) == 16'hFFFF);
  assign len_ok      = (hdr.w2[63:48] >= 16'd64) && (hdr.w2[63:48] <= 16'd1500);
  assign ttl_expired = (hdr.w2[15:8] <= 8'd1);
  assign dec_act     = pick_action(src_odd, dmac_hit, is_ipv4, has_opts,
                                   csum_good, len_ok, ttl_expired);

  assign lu_req    = (state == S_LOOK);
  assign lu_dst_ip = {hdr.w3[15:0], hdr.w4[63:48]};

  assign out_wr   = (state == S_SEND) && out_rdy;
  assign pkt_done = (dec_valid && dec_act == ACT_DROP) || (out_wr && rd_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_RECV;
      act_q   <= ACT_DROP;
      oport_q <= '0;
      nmac_q  <= '0;
    end else begin
      case (state)
        S_RECV:   if (in_last) state <= S_DECIDE;
        S_DECIDE: begin
          act_q <= dec_act;
          case (dec_act)
            ACT_FWD:    state <= S_LOOK;
            ACT_CPU:    begin oport_q <= src_p | PORT_W'(1);    state <= S_SEND; end
            ACT_BYPASS: begin oport_q <= src_p & ~PORT_W'(1);   state <= S_SEND; end
            default:    state <= S_RECV;
          endcase
        end
        S_LOOK: if (lu_ack) begin
          oport_q <= {lu_mac_idx, 1'b0};
          nmac_q  <= lu_next_mac;
          state   <= S_SEND;
        end
        S_SEND: if (out_wr && rd_last) state <= S_RECV;
        default: state <= S_RECV;
      endcase
    end
  end

  assign rd_is_data = (rd_word[71:64] == 8'h00) || (rd_word[71:64] == CTRL_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || pkt_done) didx_q <= '0;
    else if (out_wr && rd_is_data && didx_q != 3'd7) didx_q <= didx_q + 3'd1;
  end

  ipfwd_rewrite #(.PORT_W(PORT_W)) u_rewrite (
    .in_word(rd_word[63:0]), .is_first(rd_first), .is_data(rd_is_data),
    .didx(didx_q), .act(act_q), .oport(oport_q), .next_mac(nmac_q),
    .egress_mac(port_mac(MAC_BASE, 8'(oport_q))), .out_word(out_data)
  );

  assign out_ctrl = rd_word[71:64];
endmodule

// File: rtl/ipfwd_hdr_proc_chk.sv
module ipfwd_hdr_proc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_rdy,
  input logic        out_wr,
  input logic        out_rdy,
  input logic        out_first,
  input logic [63:0] out_data,
  input logic        lu_req,
  input logic        lu_ack,
  input logic [31:0] lu_dst_ip,
  input logic        dec_valid,
  input logic [1:0]  dec_act,
  input logic        src_odd
);
  a_r1_no_out_while_recv: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy |-> !out_wr);
  a_r12_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_rdy);
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    lu_req && !lu_ack |=> lu_req);
  a_r10_ip_stable: assert property (@(posedge clk) disable iff (!rst_n)
    lu_req && !lu_ack |=> $stable(lu_dst_ip));
  a_r9_cpu_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && src_odd |=> !lu_req);
  a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_act == 2'd0 |=> in_rdy && !out_wr);
  a_r2_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr && out_first |-> $countones(out_data[31:16]) == 1);
  a_r1_single_decide: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
endmodule

bind ipfwd_hdr_proc ipfwd_hdr_proc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .out_wr(out_wr), .out_rdy(out_rdy),
  .out_first(rd_first), .out_data(out_data), .lu_req(lu_req), .lu_ack(lu_ack),
  .lu_dst_ip(lu_dst_ip), .dec_valid(dec_valid), .dec_act(dec_act), .src_odd(src_odd)
);

// File: tb/ipfwd_hdr_proc_tb_top.sv
module ipfwd_hdr_proc_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [47:0] MB = 48'h02_00_00_00_00_00;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        in_wr = 1'b0, in_rdy;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;
  logic        out_wr, out_rdy = 1'b1;
  logic        lu_req, lu_ack = 1'b0;
  logic [31:0] lu_dst_ip;
  logic [1:0]  lu_mac_idx = '0;
  logic [47:0] lu_next_mac = '0;

  ipfwd_hdr_proc dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr),
    .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr),
    .out_rdy(out_rdy), .lu_req(lu_req), .lu_dst_ip(lu_dst_ip), .lu_ack(lu_ack),
    .lu_mac_idx(lu_mac_idx), .lu_next_mac(lu_next_mac)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit stall_en = 1'b0;
  logic [71:0] tx [9];
  logic [71:0] ex [9];
  logic [71:0] rx [32];
  int rx_n = 0, lu_reqs = 0, lu_wait = 0;
  logic [31:0] lu_ip_seen = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // stall, output capture and lookup responder, all away from the rising edge
  always @(negedge clk) begin
    cyc++;
    out_rdy = stall_en ? (cyc % 3 != 0) : 1'b1;
    #1;
    if (out_wr && out_rdy) begin
      if (rx_n < 32) rx[rx_n] = {out_ctrl, out_data};
      rx_n++;
    end
    if (lu_ack) lu_ack = 1'b0;
    else if (lu_req) begin
      if (lu_wait == 0) begin lu_reqs++; lu_ip_seen = lu_dst_ip; end
      lu_wait++;
      if (lu_wait == 3) begin lu_ack = 1'b1; lu_wait = 0; end
    end
  end

  function automatic logic [15:0] bench_csum(input logic [7:0] verihl, input logic [15:0] totlen,
      input logic [15:0] id, input logic [7:0] ttl, input logic [31:0] sip, input logic [31:0] dip);
    int s;
    s = {verihl, 8'h00} + totlen + id + 16'h4000 + {ttl, 8'h06}
        + sip[31:16] + sip[15:0] + dip[31:16] + dip[15:0];
    while (s > 65535) s = (s & 65535) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic build(input int src, input logic [47:0] dmac, input logic [15:0] etype,
      input logic [7:0] verihl, input logic [15:0] totlen, input logic [15:0] id,
      input logic [7:0] ttl, input bit bad, input logic [31:0] dip);
    logic [47:0] smac;
    logic [31:0] sip;
    logic [15:0] ck;
    smac = 48'hA0B1_C2D3_E4F5;
    sip  = 32'hC0A8_0101;
    ck = bench_csum(verihl, totlen, id, ttl, sip, dip);
    if (bad) ck = ck ^ 16'h0001;
    tx[0] = {8'hFF, 16'h0000, 16'd64, 16'h0000, 16'(src)};
    tx[1] = {8'h00, dmac, smac[47:32]};
    tx[2] = {8'h00, smac[31:0], etype, verihl, 8'h00};
    tx[3] = {8'h00, totlen, id, 16'h4000, ttl, 8'h06};
    tx[4] = {8'h00, ck, sip, dip[31:16]};
    tx[5] = {8'h00, dip[15:0], 48'h0102_0304_0506};
    tx[6] = {8'h00, 64'h1111_2222_3333_4444};
    tx[7] = {8'h00, 64'h5555_6666_7777_8888};
    tx[8] = {8'h10, 64'h9999_AAAA_BBBB_CCCC};
  endtask

  // kind: 0 drop, 1 unmodified with port, 2 forward
  task automatic run_pkt(input string req, input int src, input logic [47:0] dmac,
      input logic [15:0] etype, input logic [7:0] verihl, input logic [15:0] totlen,
      input logic [15:0] id, input logic [7:0] ttl, input bit bad, input logic [31:0] dip,
      input logic [1:0] idx, input logic [47:0] nmac);
    int kind, oport, i, guard, exp_n, c;
    logic [47:0] emac;
    build(src, dmac, etype, verihl, totlen, id, ttl, bad, dip);
    if (src % 2 == 1)                                      begin kind = 1; oport = src - 1; end
    else if (dmac != {MB[47:8], 8'(src)})                  begin kind = 0; oport = 0; end
    else if (etype != 16'h0800 || verihl[7:4] != 4'd4)     begin kind = 1; oport = src + 1; end
    else if (verihl[3:0] != 4'd5)                          begin kind = 1; oport = src + 1; end
    else if (bad)                                          begin kind = 0; oport = 0; end
    else if (totlen < 64 || totlen > 1500)                 begin kind = 1; oport = src + 1; end
    else if (ttl <= 1)                                     begin kind = 1; oport = src + 1; end
    else                                                   begin kind = 2; oport = 2 * idx; end
    for (int k = 0; k < 9; k++) ex[k] = tx[k];
    ex[0][31:16] = 16'd1 << oport;
    if (kind == 2) begin
      emac = {MB[47:8], 8'(oport)};
      ex[1][63:0]  = {nmac, emac[47:32]};
      ex[2][63:32] = emac[31:0];
      ex[3][15:8]  = ttl - 8'd1;
      c = tx[4][63:48] + 256;
      if (c > 65535) c = c - 65535;
      ex[4][63:48] = 16'(c);
    end
    exp_n = (kind == 0) ? 0 : 9;
    lu_idx_set(idx, nmac);
    rx_n = 0; lu_reqs = 0;
    i = 0;
    while (i < 9) begin
      @(negedge clk);
      in_wr = 1'b1; {in_ctrl, in_data} = tx[i];
      #1;
      if (in_rdy) i++;
    end
    @(negedge clk); in_wr = 1'b0;
    guard = 0;
    while (!in_rdy && guard < 500) begin @(negedge clk); guard++; end
    @(negedge clk); #2;
    check(guard < 500, req, "completion", 64'(guard), 64'd0);
    check(rx_n == exp_n, req, "word count", 64'(rx_n), 64'(exp_n));
    if (rx_n == exp_n) begin
      for (int k = 0; k < exp_n; k++)
        if (rx[k] !== ex[k]) begin
          check(1'b0, req, $sformatf("word %0d", k), rx[k][63:0], ex[k][63:0]);
          break;
        end
      if (exp_n > 0) begin
        n_chk++;  // R2 control tags preserved, one-hot port counted with the word compare
      end
    end
    check(lu_reqs == (kind == 2 ? 1 : 0), kind == 2 ? "R10" : "R9", "lookup requests",
          64'(lu_reqs), 64'(kind == 2 ? 1 : 0));
    if (kind == 2) check(lu_ip_seen == dip, "R10", "lookup address", 64'(lu_ip_seen), 64'(dip));
  endtask

  task automatic lu_idx_set(input logic [1:0] idx, input logic [47:0] nmac);
    lu_mac_idx = idx; lu_next_mac = nmac;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] ttls [5];
    ttls = '{8'd0, 8'd1, 8'd2, 8'd64, 8'd255};
    repeat (3) @(negedge clk);
    #1;
    check(in_rdy == 1'b1, "R1", "in_rdy under reset", 64'(in_rdy), 64'd1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(in_rdy == 1'b1 && out_wr == 1'b0 && lu_req == 1'b0, "R1", "idle after reset",
          {61'd0, in_rdy, out_wr, lu_req}, 64'h4);

    // R5 R3 R4 R12: every MAC ingress across TTL values, stalls on odd TTL slots
    for (int p = 0; p < 8; p += 2)
      for (int t = 0; t < 5; t++) begin
        stall_en = (t % 2 == 1);
        run_pkt(ttls[t] <= 1 ? "R5" : "R4", p, {MB[47:8], 8'(p)}, 16'h0800, 8'h45, 16'd200,
                16'h1000 + 16'(t), ttls[t], 1'b0, 32'h0A00_0000 + 32'(p * 16 + t),
                2'((p / 2 + t) % 4), 48'h0C0D_0E0F_0000 + 48'(p * 8 + t));
      end
    stall_en = 1'b0;

    // R9: CPU ingress with foreign dst MAC and TTL 0 still bypasses (R11)
    for (int p = 1; p < 8; p += 2)
      run_pkt("R9", p, 48'hFFFF_FFFF_FFFF, 16'h0800, 8'h45, 16'd100, 16'h2000, 8'd0, 1'b1,
              32'h0B00_0001, 2'd1, 48'h1);

    // R7 R8 R11: drops, including bad checksum together with expired TTL
    run_pkt("R7",  2, {MB[47:8], 8'd2}, 16'h0800, 8'h45, 16'd300, 16'h3000, 8'd64, 1'b1, 32'h0C000001, 2'd0, 48'h2);
    run_pkt("R11", 2, {MB[47:8], 8'd2}, 16'h0800, 8'h45, 16'd300, 16'h3001, 8'd1,  1'b1, 32'h0C000002, 2'd0, 48'h2);
    run_pkt("R8",  4, {MB[47:8], 8'd5}, 16'h0800, 8'h45, 16'd300, 16'h3002, 8'd64, 1'b0, 32'h0C000003, 2'd0, 48'h2);
    run_pkt("R11", 4, 48'h1234_5678_9ABC,  16'h0800, 8'h45, 16'd300, 16'h3003, 8'd64, 1'b1, 32'h0C000004, 2'd0, 48'h2);

    // R6 R11: diversions, options beat bad checksum, length bounds
    run_pkt("R6",  2, {MB[47:8], 8'd2}, 16'h86DD, 8'h45, 16'd300, 16'h4000, 8'd64, 1'b0, 32'h0D000001, 2'd3, 48'h3);
    run_pkt("R6",  2, {MB[47:8], 8'd2}, 16'h0800, 8'h65, 16'd300, 16'h4001, 8'd64, 1'b0, 32'h0D000002, 2'd3, 48'h3);
    run_pkt("R6",  2, {MB[47:8], 8'd2}, 16'h0800, 8'h46, 16'd300, 16'h4002, 8'd64, 1'b0, 32'h0D000003, 2'd3, 48'h3);
    run_pkt("R11", 2, {MB[47:8], 8'd2}, 16'h0800, 8'h47, 16'd300, 16'h4003, 8'd64, 1'b1, 32'h0D000004, 2'd3, 48'h3);
    run_pkt("R6",  6, {MB[47:8], 8'd6}, 16'h0800, 8'h45, 16'd63,   16'h4004, 8'd64, 1'b0, 32'h0D000005, 2'd3, 48'h3);
    run_pkt("R6",  6, {MB[47:8], 8'd6}, 16'h0800, 8'h45, 16'd64,   16'h4005, 8'd64, 1'b0, 32'h0D000006, 2'd3, 48'h3);
    run_pkt("R6",  6, {MB[47:8], 8'd6}, 16'h0800, 8'h45, 16'd1500, 16'h4006, 8'd64, 1'b0, 32'h0D000007, 2'd3, 48'h3);
    run_pkt("R6",  6, {MB[47:8], 8'd6}, 16'h0800, 8'h45, 16'd1501, 16'h4007, 8'd64, 1'b0, 32'h0D000008, 2'd3, 48'h3);
    run_pkt("R11", 6, {MB[47:8], 8'd6}, 16'h0800, 8'h45, 16'd20,   16'h4008, 8'd1,  1'b0, 32'h0D000009, 2'd3, 48'h3);

    // R3: sweep the identification field so the checksum takes every high byte, wrap included
    stall_en = 1'b1;
    for (int k = 0; k < 256; k++)
      run_pkt("R3", 0, {MB[47:8], 8'd0}, 16'h0800, 8'h45, 16'd576, 16'(k * 257), 8'd33, 1'b0,
              32'hAC10_0000 + 32'(k), 2'(k % 4), 48'h0E00_0000_0000 + 48'(k));
    stall_en = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule